// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the arbitration core of one eight-input interrupt controller. It keeps a request register fed by the input lines and a mask register. It also keeps an in-service register, a per-line trigger-select register and a rotatable priority base. Each clock it searches the unmasked pending requests for the best one. It raises a request toward the processor only when that candidate outranks every line already being serviced.

A command decoder in front of the block drives three things: register writes, an acknowledge strobe, and end-of-interrupt or priority commands. Lines may be edge- or level-sensitive, which changes how a request is latched and whether an acknowledge clears it. An auto-EOI mode skips in-service tracking and can optionally rotate priority. The register contents are brought out so the decoder can read them back.

Top module: `rot_prio_resolver`

## Requirements
- R1: Synchronous reset clears the request, mask and in-service registers and sets the priority base to 0, so no request is signalled. The trigger-select register keeps its value across reset.
- R2: An edge-sensitive line (trigger bit 0) sets its request bit on a low-to-high input change. A later drop of the input leaves the latched bit set.
- R3: A level-sensitive line (trigger bit 1) has its request bit follow the input one cycle later, both rising and falling.
- R4: A line whose mask bit is 1 takes no part in the search, but its request bit is still held. Clearing the mask lets it win.
- R5: With base b, line i has rank (i - b) mod 8, and rank 0 is best. The reported line is the unmasked pending line with the best rank.
- R6: The request output is raised only when the winner's rank is strictly better than the best rank in service. A request equal to or below an in-service line is held off.
- R7: An acknowledge taken while a request is signalled, outside auto-EOI, sets the winner's in-service bit. It clears the winner's request bit only for an edge-sensitive line.
- R8: In auto-EOI mode an acknowledge sets no in-service bit. If rotate-on-auto-EOI is on, the base becomes (winner + 1) mod 8; otherwise the base is unchanged.
- R9: Command code 0 clears the best-ranked in-service bit. Code 2 does the same and also sets the base to that line + 1 mod 8.
- R10: Command code 1 clears the in-service bit named by the 3-bit line field. Code 3 does the same and also sets the base to field + 1 mod 8.
- R11: Command code 4 sets the base to field + 1 mod 8 and leaves the in-service register unchanged. Codes 5 to 7 do nothing.
- R12: An acknowledge strobe while no request is signalled changes neither the in-service register nor the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Interrupt request lines |
| trig_wr | input | 1 | Load trigger-select register |
| trig_wdata | input | 8 | Trigger select data, 1 = level, 0 = edge |
| mask_wr | input | 1 | Load mask register |
| mask_wdata | input | 8 | Mask data, 1 = masked |
| auto_eoi | input | 1 | Auto-EOI mode |
| rot_aeoi | input | 1 | Rotate base on auto-EOI acknowledge |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..4 as in R9-R11) |
| cmd_line | input | 3 | Line field of the command |
| irq_valid | output | 1 | Request toward processor |
| irq_line | output | 3 | Winning line number |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| mask_o | output | 8 | Mask register |
| trig_o | output | 8 | Trigger-select register |
| base_o | output | 3 | Current priority base |

## Verification
The assertions assume that acknowledge and command strobes last one cycle and arrive only from a decoder that has finished its register writes. They also assume that the trigger select of a line does not change while that line holds a request. The stimulus keeps to this by driving every strobe for exactly one clock. It reprograms trigger select only right after reset or with all request lines low. It never issues an acknowledge and a command in the same cycle.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

    typedef enum logic [2:0] {
        OP_EOI_ANY      = 3'd0,
        OP_EOI_LINE     = 3'd1,
        OP_EOI_ANY_ROT  = 3'd2,
        OP_EOI_LINE_ROT = 3'd3,
        OP_SET_BASE     = 3'd4
    } eoi_op_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] op;
    } cmd_hdr_t;

    // next index around a ring of n entries
    function automatic int wrap_next(input int v, input int n);
        return (v + 1) % n;
    endfunction

endpackage

// File: rtl/rpr_prio_search.sv
module rpr_prio_search #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int PW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] base,
    output logic [PW-1:0] rank,
    output logic [IW-1:0] line
);
    // scan from worst rank to best so the best set entry is kept last
    always_comb begin
        rank = PW'(N);
        line = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(base) + k) % N;
            if (vec[idx]) begin
                rank = PW'(k);
                line = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/rpr_req_capture.sv
module rpr_req_capture #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_in,
    input  logic [N-1:0]  trig,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_line,
    output logic [N-1:0]  irr
);
    logic [N-1:0] prev_q;
    logic [N-1:0] irr_q;
    logic [N-1:0] irr_d;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic hit;
        assign hit = clr_en && (clr_line == IW'(g));
        always_comb begin
            if (trig[g])
                irr_d[g] = req_in[g];
            else
                irr_d[g] = (irr_q[g] & ~hit) | (req_in[g] & ~prev_q[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= req_in;
            irr_q  <= irr_d;
        end
    end

    assign irr = irr_q;
endmodule

// File: rtl/rpr_service.sv
module rpr_service
    import rpr_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ack_take,
    input  logic [IW-1:0] ack_line,
    input  logic          auto_eoi,
    input  logic          rot_aeoi,
    input  cmd_hdr_t      cmd,
    input  logic [IW-1:0] cmd_line,
    input  logic          top_found,
    input  logic [IW-1:0] top_line,
    output logic [N-1:0]  isr,
    output logic [IW-1:0] base
);
    logic [N-1:0]  isr_q, isr_set, isr_clr;
    logic [IW-1:0] base_q, base_d;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] v);
        return IW'(wrap_next(int'(v), N));
    endfunction

    always_comb begin
        isr_set = '0;
        isr_clr = '0;
        base_d  = base_q;
        if (ack_take) begin
            if (!auto_eoi)
                isr_set[ack_line] = 1'b1;
            else if (rot_aeoi)
                base_d = step(ack_line);
        end
        if (cmd.valid) begin
            unique case (cmd.op)
                OP_EOI_ANY: begin
                    if (top_found) isr_clr[top_line] = 1'b1;
                end
                OP_EOI_ANY_ROT: begin
                    if (top_found) begin
                        isr_clr[top_line] = 1'b1;
                        base_d = step(top_line);
                    end
                end
                OP_EOI_LINE: isr_clr[cmd_line] = 1'b1;
                OP_EOI_LINE_ROT: begin
                    isr_clr[cmd_line] = 1'b1;
                    base_d = step(cmd_line);
                end
                OP_SET_BASE: base_d = step(cmd_line);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q  <= '0;
            base_q <= '0;
        end else begin
            isr_q  <= (isr_q | isr_set) & ~isr_clr;
            base_q <= base_d;
        end
    end

    assign isr  = isr_q;
    assign base = base_q;
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
    import rpr_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int PW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_in,
    input  logic          trig_wr,
    input  logic [N-1:0]  trig_wdata,
    input  logic          mask_wr,
    input  logic [N-1:0]  mask_wdata,
    input  logic          auto_eoi,
    input  logic          rot_aeoi,
    input  logic          ack_i,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [IW-1:0] cmd_line,
    output logic          irq_valid,
    output logic [IW-1:0] irq_line,
    output logic [N-1:0]  irr_o,
    output logic [N-1:0]  isr_o,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  trig_o,
    output logic [IW-1:0] base_o
);
    logic [N-1:0]  trig_q, mask_q, irr_w, isr_w;
    logic [IW-1:0] base_w;
    logic [PW-1:0] pend_rank, svc_rank;
    logic [IW-1:0] pend_line, svc_line;
    logic          ack_take;
    cmd_hdr_t      cmd;

    // trigger select survives reset on purpose
    always_ff @(posedge clk) begin
        if (trig_wr) trig_q <= trig_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    assign cmd      = '{valid: cmd_valid, op: cmd_op};
    assign ack_take = ack_i && irq_valid;

    rpr_req_capture #(.N(N), .IW(IW)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .req_in   (req_in),
        .trig     (trig_q),
        .clr_en   (ack_take && !trig_q[irq_line]),
        .clr_line (irq_line),
        .irr      (irr_w)
    );

    rpr_prio_search #(.N(N), .IW(IW), .PW(PW)) u_pend (
        .vec  (irr_w & ~mask_q),
        .base (base_w),
        .rank (pend_rank),
        .line (pend_line)
    );

    rpr_prio_search #(.N(N), .IW(IW), .PW(PW)) u_svc (
        .vec  (isr_w),
        .base (base_w),
        .rank (svc_rank),
        .line (svc_line)
    );

    rpr_service #(.N(N), .IW(IW)) u_svc_ctl (
        .clk       (clk),
        .rst       (rst),
        .ack_take  (ack_take),
        .ack_line  (irq_line),
        .auto_eoi  (auto_eoi),
        .rot_aeoi  (rot_aeoi),
        .cmd       (cmd),
        .cmd_line  (cmd_line),
        .top_found (svc_rank != PW'(N)),
        .top_line  (svc_line),
        .isr       (isr_w),
        .base      (base_w)
    );

    // an empty pending set has rank N, which is never below svc_rank
    assign irq_valid = pend_rank < svc_rank;
    assign irq_line  = pend_line;
    assign irr_o     = irr_w;
    assign isr_o     = isr_w;
    assign mask_o    = mask_q;
    assign trig_o    = trig_q;
    assign base_o    = base_w;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker
    import rpr_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  req_in,
    input logic          ack_i,
    input logic          auto_eoi,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [IW-1:0] cmd_line,
    input logic [N-1:0]  irr,
    input logic [N-1:0]  isr,
    input logic [N-1:0]  mask,
    input logic [N-1:0]  trig,
    input logic [IW-1:0] base,
    input logic          irq_valid,
    input logic [IW-1:0] irq_line
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    p_valid_pending_r4: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irr[irq_line] && !mask[irq_line]));

    p_valid_not_serviced_r6: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !isr[irq_line]);

    p_edge_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(ack_i)) |-> ((($past(irr) & ~$past(trig)) & ~irr) == '0));

    p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
        armed |-> (((irr ^ $past(req_in)) & $past(trig)) == '0));

    p_aeoi_no_isr_r8: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(auto_eoi && ack_i && !cmd_valid)) |-> ((isr & ~$past(isr)) == '0));

    p_set_base_r11: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(cmd_valid && cmd_op == 3'(OP_SET_BASE)))
            |-> (base == IW'(wrap_next(int'($past(cmd_line)), N))));
endmodule

bind rot_prio_resolver rpr_checker #(.N(N), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_in    (req_in),
    .ack_i     (ack_i),
    .auto_eoi  (auto_eoi),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_line  (cmd_line),
    .irr       (irr_w),
    .isr       (isr_w),
    .mask      (mask_q),
    .trig      (trig_q),
    .base      (base_w),
    .irq_valid (irq_valid),
    .irq_line  (irq_line)
);

// File: tb/tb_rot_prio_resolver.sv
module tb_rot_prio_resolver;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0;
    logic       trig_wr = 1'b0, mask_wr = 1'b0;
    logic [7:0] trig_wdata = '0, mask_wdata = '0;
    logic       auto_eoi = 1'b0, rot_aeoi = 1'b0, ack_i = 1'b0, cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0, cmd_line = '0;
    logic       irq_valid;
    logic [2:0] irq_line, base_o;
    logic [7:0] irr_o, isr_o, mask_o, trig_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rot_prio_resolver dut (
        .clk(clk), .rst(rst), .req_in(req_in),
        .trig_wr(trig_wr), .trig_wdata(trig_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .ack_i(ack_i),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .irq_valid(irq_valid), .irq_line(irq_line),
        .irr_o(irr_o), .isr_o(isr_o), .mask_o(mask_o), .trig_o(trig_o),
        .base_o(base_o)
    );

    // {base field, mask, requests, expected valid, expected line}; all lines level
    localparam int NV = 10;
    localparam logic [22:0] VEC [NV] = '{
        {3'd7, 8'h00, 8'h00, 1'b0, 3'd0},
        {3'd7, 8'h00, 8'h81, 1'b1, 3'd0},
        {3'd7, 8'h01, 8'h81, 1'b1, 3'd7},
        {3'd3, 8'h00, 8'h81, 1'b1, 3'd7},
        {3'd3, 8'h00, 8'h18, 1'b1, 3'd4},
        {3'd4, 8'h00, 8'h18, 1'b1, 3'd3},
        {3'd6, 8'h00, 8'h7E, 1'b1, 3'd1},
        {3'd2, 8'hFF, 8'hFF, 1'b0, 3'd0},
        {3'd2, 8'h08, 8'h0C, 1'b1, 3'd2},
        {3'd0, 8'h00, 8'h01, 1'b1, 3'd0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        req_in = '0;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [2:0] ln);
        cmd_valid = 1'b1; cmd_op = op; cmd_line = ln;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic ack();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        trig_wr = 1'b1; trig_wdata = 8'h00;
        tick(); tick(); tick();
        trig_wr = 1'b0;
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1", "irr", irr_o, 8'h00);
        chk("R1", "isr", isr_o, 8'h00);
        chk("R1", "mask", mask_o, 8'h00);
        chk("R1", "base", base_o, 3'd0);
        chk("R1", "valid", irq_valid, 1'b0);
        trig_wr = 1'b1; trig_wdata = 8'hA5; mask_wr = 1'b1; mask_wdata = 8'h3C;
        tick();
        trig_wr = 1'b0; mask_wr = 1'b0;
        do_reset();
        tick();
        chk("R1", "trig kept", trig_o, 8'hA5);
        chk("R1", "mask cleared", mask_o, 8'h00);

        // R5 table walk, all lines level sensitive
        trig_wr = 1'b1; trig_wdata = 8'hFF;
        tick();
        trig_wr = 1'b0;
        for (int i = 0; i < NV; i++) begin
            mask_wr = 1'b1; mask_wdata = VEC[i][19:12];
            req_in = VEC[i][11:4];
            cmd(3'd4, VEC[i][22:20]);
            mask_wr = 1'b0;
            tick();
            chk("R5", "table valid", irq_valid, VEC[i][3]);
            if (VEC[i][3]) chk("R5", "table line", irq_line, VEC[i][2:0]);
        end

        // edge capture, ack, strict outrank
        req_in = '0;
        trig_wr = 1'b1; trig_wdata = 8'h00;
        tick();
        trig_wr = 1'b0;
        do_reset();
        req_in[5] = 1'b1; tick();
        chk("R2", "edge set", irr_o, 8'h20);
        chk("R5", "line5", irq_line, 3'd5);
        req_in[5] = 1'b0; tick();
        chk("R2", "edge held after drop", irr_o, 8'h20);
        ack();
        chk("R7", "isr after ack", isr_o, 8'h20);
        chk("R7", "edge irr cleared", irr_o, 8'h00);
        req_in[6] = 1'b1; tick();
        chk("R6", "lower rank held off", irq_valid, 1'b0);
        req_in[5] = 1'b1; tick();
        chk("R6", "equal rank held off", irq_valid, 1'b0);
        req_in[2] = 1'b1; tick();
        chk("R6", "higher rank valid", irq_valid, 1'b1);
        chk("R6", "higher rank line", irq_line, 3'd2);

        // nested service, EOI variants
        do_reset();
        req_in[3] = 1'b1; tick();
        ack();
        req_in[1] = 1'b1; tick();
        chk("R6", "nested valid", irq_valid, 1'b1);
        ack();
        chk("R7", "nested isr", isr_o, 8'h0A);
        cmd(3'd0, 3'd0);
        chk("R9", "plain eoi clears best", isr_o, 8'h08);
        cmd(3'd1, 3'd3);
        chk("R10", "specific eoi", isr_o, 8'h00);
        cmd(3'd3, 3'd6);
        chk("R10", "rot specific base", base_o, 3'd7);
        cmd(3'd6, 3'd2);
        chk("R11", "unused code base", base_o, 3'd7);

        // set base keeps isr; rotating non-specific eoi
        do_reset();
        req_in[4] = 1'b1; tick();
        ack();
        cmd(3'd4, 3'd5);
        chk("R11", "set base", base_o, 3'd6);
        chk("R11", "isr untouched", isr_o, 8'h10);
        cmd(3'd2, 3'd0);
        chk("R9", "rot eoi isr", isr_o, 8'h00);
        chk("R9", "rot eoi base", base_o, 3'd5);

        // auto-EOI
        do_reset();
        auto_eoi = 1'b1;
        req_in[2] = 1'b1; tick();
        ack();
        chk("R8", "aeoi isr", isr_o, 8'h00);
        chk("R8", "aeoi irr", irr_o, 8'h00);
        chk("R8", "aeoi no rotate", base_o, 3'd0);
        rot_aeoi = 1'b1;
        req_in[4] = 1'b1; tick();
        ack();
        chk("R8", "aeoi rotate base", base_o, 3'd5);
        rot_aeoi = 1'b0; auto_eoi = 1'b0;

        // level line ack
        do_reset();
        trig_wr = 1'b1; trig_wdata = 8'h01;
        tick();
        trig_wr = 1'b0;
        req_in[0] = 1'b1; tick();
        chk("R3", "level set", irr_o, 8'h01);
        ack();
        chk("R7", "level isr", isr_o, 8'h01);
        chk("R7", "level irr kept", irr_o, 8'h01);
        req_in[0] = 1'b0; tick();
        chk("R3", "level clear", irr_o, 8'h00);

        // mask
        do_reset();
        mask_wr = 1'b1; mask_wdata = 8'h08; tick();
        mask_wr = 1'b0;
        req_in[3] = 1'b1; tick();
        chk("R4", "masked not valid", irq_valid, 1'b0);
        chk("R4", "masked irr held", irr_o, 8'h08);
        mask_wr = 1'b1; mask_wdata = 8'h00; tick();
        mask_wr = 1'b0;
        chk("R4", "unmasked valid", irq_valid, 1'b1);
        chk("R4", "unmasked line", irq_line, 3'd3);

        // ack with nothing signalled
        do_reset();
        auto_eoi = 1'b1; rot_aeoi = 1'b1;
        ack();
        chk("R12", "idle ack base", base_o, 3'd0);
        auto_eoi = 1'b0; rot_aeoi = 1'b0;
        ack();
        chk("R12", "idle ack isr", isr_o, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule